// File: doc/BRIEF.md
# Vector Element Step and Batch Controller

This block keeps track of which vector elements the current instruction operates on. It supports two looping styles. In horizontal-first mode, every issued instruction moves the element step forward by one until it reaches the vector length. In vertical-first mode, issuing instructions leaves the step where it is. Only an explicit step command advances it, and each command moves it by a batch size that the hardware grants.

Software configures four values through a small write port: a maximum length, a requested vector length, a requested batch hint and the mode bit. The block clamps each request to what is legal and to what the hardware can do. It presents three things: the source and destination step values, a per-lane mask of the elements active in the current batch, and an exhausted flag. A loop-back branch tests that flag to decide whether to leave the loop. The final batch of a loop is cut short at the limit. The limit is the vector length in horizontal-first mode and the maximum length in vertical-first mode.

Top module: `vec_step_ctrl`

## Requirements
- R1: After reset, the maximum length, the vector length and the hint are all 1, the mode is horizontal-first, both steps are 0, the flag is 0 and the mask is 0b0001.
- R2: Writes use `cfg_sel` 0 for the maximum length, 1 for the vector length, 2 for the hint and 3 for the mode, where `cfg_data[0]`=1 selects vertical-first. A written value of 0 is taken as 1. A vector length above the maximum length is clamped to the maximum length. Writing a smaller maximum length also lowers the vector length to it.
- R3: The granted batch is the smallest of the hint (0 taken as 1), the vector length and LANES.
- R4: Once a loop has started (step not 0, or the flag set), a hint write is ignored, so the grant stays fixed for the rest of the loop.
- R5: In vertical-first mode, an issue strobe leaves both steps unchanged.
- R6: In vertical-first mode, each step command advances the source and destination steps together by the grant. The steps saturate at the maximum length.
- R7: Lane i of the mask is set when the flag is clear, i is below the grant (the grant is 1 in horizontal-first mode) and step+i is below the limit.
- R8: The flag sets when an advance makes the step reach or pass the limit. While the flag is set, strobes change nothing.
- R9: In horizontal-first mode, each issue strobe advances the step by one up to the vector length. A step command has no effect in this mode.
- R10: Writing the maximum length, the vector length or the mode returns both steps to 0 and clears the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Register select: 0 max length, 1 vector length, 2 hint, 3 mode |
| cfg_data | input | LEN_W | Write data |
| issue | input | 1 | Instruction-issue strobe |
| step_cmd | input | 1 | Explicit step command |
| src_step | output | LEN_W | Source element step |
| dst_step | output | LEN_W | Destination element step |
| lane_mask | output | LANES | Active lanes for the current batch |
| exhausted | output | 1 | Loop limit reached |

## Verification
The bench builds the block with LANES=4 and LEN_W=5. It sweeps every maximum length from 1 to 10, every vector length up to that maximum, and hints from 0 to one past the vector length. With four lanes, this sweep covers grants limited by the hint, by the vector length and by the lane count. It also covers truncated last batches and batches that divide the limit exactly. Horizontal-first runs cover vector-length requests of 0, in range and above the maximum. Further runs cover mid-loop hint and mode writes.

// File: rtl/vec_step_ctrl.sv
`timescale 1ns/1ps
module vec_step_ctrl #(
  parameter int LANES = 4,
  parameter int LEN_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [1:0]       cfg_sel,
  input  logic [LEN_W-1:0] cfg_data,
  input  logic             issue,
  input  logic             step_cmd,
  output logic [LEN_W-1:0] src_step,
  output logic [LEN_W-1:0] dst_step,
  output logic [LANES-1:0] lane_mask,
  output logic             exhausted
);
  localparam logic [1:0] SEL_MVL = 2'd0, SEL_VL = 2'd1, SEL_HINT = 2'd2, SEL_MODE = 2'd3;
  localparam logic [LEN_W-1:0] LANE_CAP = LEN_W'(LANES);
  localparam logic [LEN_W-1:0] ONE = LEN_W'(1);

  function automatic logic [LEN_W-1:0] umin(input logic [LEN_W-1:0] a, input logic [LEN_W-1:0] b);
    return (a < b) ? a : b;
  endfunction

  logic [LEN_W-1:0] mvl_q, vl_q, hint_q, batch_q, step_q;
  logic             vf_q, done_q;
  logic [LEN_W-1:0] mvl_n, vl_n, hint_n;
  logic             vf_n;

  wire [LEN_W-1:0] din     = (cfg_data == '0) ? ONE : cfg_data;
  wire             idle    = (step_q == '0) && !done_q;
  wire             restart = cfg_we && (cfg_sel != SEL_HINT);
  wire [LEN_W-1:0] limit   = vf_q ? mvl_q : vl_q;
  wire [LEN_W-1:0] stride  = vf_q ? batch_q : ONE;
  wire [LEN_W:0]   sum     = {1'b0, step_q} + {1'b0, stride};
  wire             reached = sum >= {1'b0, limit};
  wire             adv     = vf_q ? step_cmd : issue;

  always_comb begin
    mvl_n  = mvl_q;
    vl_n   = vl_q;
    hint_n = hint_q;
    vf_n   = vf_q;
    if (cfg_we) begin
      case (cfg_sel)
        SEL_MVL: begin
          mvl_n  = din;
          vl_n   = umin(vl_q, din);
          hint_n = umin(hint_q, vl_n);
        end
        SEL_VL: begin
          vl_n   = umin(din, mvl_q);
          hint_n = umin(hint_q, vl_n);
        end
        SEL_HINT: if (idle) hint_n = umin(din, vl_q);
        default:  vf_n = cfg_data[0];
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mvl_q   <= ONE;
      vl_q    <= ONE;
      hint_q  <= ONE;
      batch_q <= ONE;
      vf_q    <= 1'b0;
      step_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      mvl_q   <= mvl_n;
      vl_q    <= vl_n;
      hint_q  <= hint_n;
      batch_q <= umin(hint_n, LANE_CAP);
      vf_q    <= vf_n;
      if (restart) begin
        step_q <= '0;
        done_q <= 1'b0;
      end else if (adv && !done_q) begin
        step_q <= reached ? limit : sum[LEN_W-1:0];
        done_q <= reached;
      end
    end
  end

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign lane_mask[i] = !done_q && (LEN_W'(i) < stride) &&
                          (({1'b0, step_q} + (LEN_W+1)'(i)) < {1'b0, limit});
  end

  assign src_step  = step_q;
  assign dst_step  = step_q;
  assign exhausted = done_q;

  assert_vl_within_mvl_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (vl_q != '0) && (vl_q <= mvl_q));
  assert_grant_bounds_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (batch_q != '0) && (batch_q <= vl_q) && (batch_q <= LANE_CAP));
  assert_grant_fixed_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we |=> $stable(batch_q));
  assert_vf_issue_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (vf_q && !cfg_we && !step_cmd) |=> $stable(step_q));
  assert_step_in_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    step_q <= limit);
  assert_done_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (lane_mask == '0));
  assert_restart_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (step_q == '0) && !done_q);
endmodule

// File: tb/vec_step_ctrl_tb_top.sv
`timescale 1ns/1ps
module vec_step_ctrl_tb_top;
  localparam int LANES = 4;
  localparam int LEN_W = 5;

  logic clk = 0, rst_n = 0, cfg_we = 0, issue = 0, step_cmd = 0;
  logic [1:0] cfg_sel = 0;
  logic [LEN_W-1:0] cfg_data = 0;
  logic [LEN_W-1:0] src_step, dst_step;
  logic [LANES-1:0] lane_mask;
  logic exhausted;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  vec_step_ctrl #(.LANES(LANES), .LEN_W(LEN_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_data(cfg_data),
    .issue(issue), .step_cmd(step_cmd), .src_step(src_step), .dst_step(dst_step),
    .lane_mask(lane_mask), .exhausted(exhausted));

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cfg(int sel, int d);
    @(negedge clk); cfg_we = 1; cfg_sel = 2'(sel); cfg_data = LEN_W'(d);
    @(negedge clk); cfg_we = 0;
  endtask

  task automatic pulse_step();
    @(negedge clk); step_cmd = 1;
    @(negedge clk); step_cmd = 0;
  endtask

  task automatic pulse_issue();
    @(negedge clk); issue = 1;
    @(negedge clk); issue = 0;
  endtask

  function automatic int imin(int a, int b);
    return a < b ? a : b;
  endfunction

  function automatic int exp_mask(int s, int g, int lim, bit d);
    int m = 0;
    for (int i = 0; i < LANES; i++)
      if (!d && i < g && s + i < lim) m |= (1 << i);
    return m;
  endfunction

  task automatic expect_state(string tag, int s, int g, int lim, bit d);
    chk({tag, " src"}, src_step, s);
    chk({tag, " dst"}, dst_step, s);
    chk({tag, " mask R7"}, lane_mask, exp_mask(s, g, lim, d));
    chk({tag, " flag R8"}, exhausted, d);
  endtask

  initial begin
    #1_600_000;
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    expect_state("R1 reset", 0, 1, 1, 0);

    // Vertical-first sweep: R3 R5 R6 R7 R8 R4
    for (int m = 1; m <= 10; m++)
      for (int v = 1; v <= m; v++)
        for (int h = 0; h <= v + 1; h++) begin
          int g, k, s;
          bit d;
          cfg(0, m); cfg(1, v); cfg(2, h); cfg(3, 1);
          g = imin(imin(h == 0 ? 1 : h, v), LANES);
          expect_state("R3 grant", 0, g, m, 0);
          pulse_issue();
          expect_state("R5 issue hold", 0, g, m, 0);
          k = 0; d = 0;
          while (!d) begin
            pulse_step();
            k++;
            s = imin(k * g, m);
            d = (k * g >= m);
            expect_state("R6 step", s, g, m, d);
            if (k == 1 && !d) begin
              cfg(2, (g % LANES) + 1);
              expect_state("R4 hint ignored", s, g, m, d);
            end
          end
          pulse_step();
          pulse_issue();
          expect_state("R8 held", m, g, m, 1);
        end

    // Horizontal-first with VL requests incl. 0 and above MVL: R9 R2
    cfg(0, 10);
    for (int v = 0; v <= 12; v++) begin
      int ve;
      ve = (v == 0) ? 1 : imin(v, 10);
      cfg(3, 0); cfg(1, v);
      pulse_step();
      expect_state("R9 step ignored", 0, 1, ve, 0);
      for (int k = 1; k <= ve; k++) begin
        pulse_issue();
        expect_state("R9 R2 issue", k, 1, ve, k >= ve);
      end
      pulse_issue();
      expect_state("R9 after end", ve, 1, ve, 1);
    end

    // MVL write lowers VL: R2
    cfg(0, 10); cfg(3, 0); cfg(1, 8); cfg(0, 5);
    for (int k = 1; k <= 5; k++) pulse_issue();
    expect_state("R2 lowered vl", 5, 1, 5, 1);
    // MVL zero taken as one
    cfg(0, 0); cfg(3, 1); cfg(2, 3);
    expect_state("R2 mvl zero", 0, 1, 1, 0);
    pulse_step();
    expect_state("R2 mvl zero step", 1, 1, 1, 1);

    // Mid-loop restart writes: R10
    cfg(0, 12); cfg(1, 12); cfg(2, 4); cfg(3, 1);
    pulse_step();
    expect_state("R10 pre", 4, 4, 12, 0);
    cfg(3, 1);
    expect_state("R10 mode write", 0, 4, 12, 0);
    pulse_step(); pulse_step(); pulse_step();
    expect_state("R10 done", 12, 4, 12, 1);
    cfg(1, 12);
    expect_state("R10 vl write", 0, 4, 12, 0);
    pulse_step();
    cfg(0, 12);
    expect_state("R10 mvl write", 0, 4, 12, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule